// File: doc/BRIEF.md
# Switch and Scratch Register Peripheral Bus Target

This block is a completer on an APB peripheral bus with an 8-bit byte offset. It lets software read the state of two single-bit switch inputs, each at its own word offset, and it holds one 32-bit word that software can write and read back. Every transfer runs as a single setup cycle followed by a single access cycle. The block never inserts wait states.

Each switch input comes from outside the clock domain. It passes through a two-stage synchroniser before any read can return it. A read of a switch returns the synchronised level in bit 0, with every other bit zero. An access to an offset with nothing behind it ends with the error response. A write to either read-only switch word also ends with the error response. Reset is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset on a clock edge.

Top module: `apb_switch_reg`

## Requirements
- R1: After reset, the outputs `prdata`, `pready` and `pslverr` are zero, and a read at offset 0x08 returns 0x0000_0000.
- R2: `pready` is high in every cycle with `psel` and `penable` both high, and low in every other cycle. No transfer takes more than one access cycle.
- R3: A read at offset 0x00 returns the synchronised level of `sw_a_in` in bit 0 and zero in bits 31:1.
- R4: A read at offset 0x04 returns the synchronised level of `sw_b_in` in bit 0 and zero in bits 31:1.
- R5: A switch level reaches the read data only after it has been captured by two rising clock edges. A read whose access cycle falls one edge after the input changes still returns the old level.
- R6: A write at offset 0x08 stores `pwdata` on the rising edge that ends its access cycle. Later reads at offset 0x08 return the stored word.
- R7: The stored word changes in no other case. A setup cycle (`psel` high, `penable` low) with `pwrite` high does not change it. Nor does any cycle with `psel` low, whatever `penable`, `pwrite` and `paddr` are.
- R8: Any offset other than 0x00, 0x04 and 0x08 is unmapped, and 0x09 is one example. A read or write at an unmapped offset ends with `pslverr` high and `prdata` zero, and the stored word does not change.
- R9: A write at offset 0x00 or 0x04 ends with `pslverr` high and has no effect on the stored word.
- R10: `prdata` is zero whenever `psel` is low.
- R11: `pslverr` is high only in an access cycle, and it is low for every mapped read and for writes at offset 0x08.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Target select |
| penable | input | 1 | High in the access cycle of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset within the target |
| pwdata | input | 32 | Write data |
| sw_a_in | input | 1 | Asynchronous switch A level |
| sw_b_in | input | 1 | Asynchronous switch B level |
| prdata | output | 32 | Read data, valid in the access cycle of a read |
| pready | output | 1 | Transfer complete |
| pslverr | output | 1 | Error response for the transfer |

## Verification
The hardest case to reach is a read that lands inside the synchroniser window. A switch has just changed, but only one of the two capture edges has passed, so the read must still return the old level. To reach it, the bench changes a switch on the same falling edge on which it starts the setup cycle of a read. The access cycle then falls exactly one rising edge later. The next back-to-back read must then return the new level. Random traffic adds switch changes and transfers at mapped, unmapped and read-only offsets. It lets the switches settle before each random read, and it checks every response against a model of the stored word.

// File: rtl/apbsw_pkg.sv
`timescale 1ns/1ps
package apbsw_pkg;
  typedef enum logic [1:0] {
    RGN_SW_A = 2'd0,
    RGN_SW_B = 2'd1,
    RGN_WORD = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  localparam int unsigned DEF_ADDR_W   = 8;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_SYNC_LEN = 2;
endpackage

// File: rtl/apbsw_rst_sync.sv
`timescale 1ns/1ps
module apbsw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/apbsw_sync.sv
`timescale 1ns/1ps
module apbsw_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int unsigned TOTAL = WIDTH * STAGES;

  logic [TOTAL-1:0] chain_q;
  logic [TOTAL-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = din;
    end else begin : g_multi
      always_comb chain_d = {chain_q[TOTAL-WIDTH-1:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[TOTAL-1 -: WIDTH];
endmodule

// File: rtl/apbsw_decode.sv
`timescale 1ns/1ps
module apbsw_decode
  import apbsw_pkg::*;
#(
  parameter int unsigned     ADDR_W   = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] OFF_SW_A = 'h00,
  parameter logic [ADDR_W-1:0] OFF_SW_B = 'h04,
  parameter logic [ADDR_W-1:0] OFF_WORD = 'h08
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output region_e           region,
  output logic              bad
);
  always_comb begin
    if      (addr == OFF_SW_A) region = RGN_SW_A;
    else if (addr == OFF_SW_B) region = RGN_SW_B;
    else if (addr == OFF_WORD) region = RGN_WORD;
    else                       region = RGN_NONE;
  end

  always_comb begin
    unique case (region)
      RGN_SW_A, RGN_SW_B: bad = wr;
      RGN_WORD:           bad = 1'b0;
      default:            bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/apbsw_word.sv
`timescale 1ns/1ps
module apbsw_word #(
  parameter int unsigned       DATA_W = 32,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (we) word_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= RST_VAL;
    else        word_q <= word_d;
  end

  assign q = word_q;
endmodule

// File: rtl/apb_switch_reg.sv
`timescale 1ns/1ps
module apb_switch_reg
  import apbsw_pkg::*;
#(
  parameter int unsigned       ADDR_W   = DEF_ADDR_W,
  parameter int unsigned       DATA_W   = DEF_DATA_W,
  parameter int unsigned       SYNC_LEN = DEF_SYNC_LEN,
  parameter logic [ADDR_W-1:0] OFF_SW_A = 'h00,
  parameter logic [ADDR_W-1:0] OFF_SW_B = 'h04,
  parameter logic [ADDR_W-1:0] OFF_WORD = 'h08,
  parameter logic [DATA_W-1:0] WORD_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic              sw_a_in,
  input  logic              sw_b_in,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr
);
  localparam int unsigned NUM_SW = 2;

  logic              rst_core_n;
  logic [NUM_SW-1:0] sw_raw;
  logic [NUM_SW-1:0] sw_sync;
  region_e           region;
  logic              bad;
  logic              access;
  logic              word_we;
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] rd_mux;

  apbsw_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_core_n)
  );

  assign sw_raw = {sw_b_in, sw_a_in};

  apbsw_sync #(.WIDTH(NUM_SW), .STAGES(SYNC_LEN)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .din   (sw_raw),
    .dout  (sw_sync)
  );

  apbsw_decode #(
    .ADDR_W   (ADDR_W),
    .OFF_SW_A (OFF_SW_A),
    .OFF_SW_B (OFF_SW_B),
    .OFF_WORD (OFF_WORD)
  ) u_dec (
    .addr   (paddr),
    .wr     (pwrite),
    .region (region),
    .bad    (bad)
  );

  assign access  = psel & penable;
  assign word_we = access & pwrite & (region == RGN_WORD);

  apbsw_word #(.DATA_W(DATA_W), .RST_VAL(WORD_RST)) u_word (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (word_we),
    .wdata (pwdata),
    .q     (word_q)
  );

  always_comb begin
    rd_mux = '0;
    unique case (region)
      RGN_SW_A: rd_mux[0] = sw_sync[0];
      RGN_SW_B: rd_mux[0] = sw_sync[1];
      RGN_WORD: rd_mux    = word_q;
      default:  rd_mux    = '0;
    endcase
  end

  always_comb begin
    pready  = access;
    pslverr = access & bad;
    prdata  = (access & ~pwrite & ~bad) ? rd_mux : '0;
  end
endmodule

// File: rtl/apbsw_checker.sv
`timescale 1ns/1ps
module apbsw_checker #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic              sw_a_in,
  input logic              sw_b_in,
  input logic [DATA_W-1:0] prdata,
  input logic              pready,
  input logic              pslverr
);
  logic [2:0]        settle_q;
  logic              live;
  logic [DATA_W-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             settle_q <= '0;
    else if (settle_q != 3'd7) settle_q <= settle_q + 3'd1;
  end
  assign live = (settle_q == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else if (psel && penable && pwrite && paddr == 8'h08) shadow_q <= pwdata;
  end

  AST_READY_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable) |-> pready);                                       // R2
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable) |-> !pready);                                     // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !psel |-> (prdata == '0));                                           // R10
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (prdata == '0));                                         // R8
  AST_ERR_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (psel && penable));                                      // R11
  AST_SW_A_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (psel && penable && !pwrite && paddr == 8'h00) |-> (prdata == {{(DATA_W-1){1'b0}}, $past(sw_a_in, 2)})); // R5
  AST_SW_B_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (psel && penable && !pwrite && paddr == 8'h04) |-> (prdata == {{(DATA_W-1){1'b0}}, $past(sw_b_in, 2)})); // R4
  AST_WORD_READBACK: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (psel && penable && !pwrite && paddr == 8'h08) |-> (prdata == shadow_q)); // R6
endmodule

bind apb_switch_reg apbsw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .pwdata  (pwdata),
  .sw_a_in (sw_a_in),
  .sw_b_in (sw_b_in),
  .prdata  (prdata),
  .pready  (pready),
  .pslverr (pslverr)
);

// File: tb/tb_apb_switch_reg.sv
`timescale 1ns/1ps
module tb_apb_switch_reg;
  logic        clk;
  logic        rst_n;
  logic        psel;
  logic        penable;
  logic        pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata;
  logic        sw_a_in;
  logic        sw_b_in;
  logic [31:0] prdata;
  logic        pready;
  logic        pslverr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] model_word;

  apb_switch_reg dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .sw_a_in(sw_a_in), .sw_b_in(sw_b_in),
    .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic exp_err(input logic wr, input logic [7:0] a);
    if (a == 8'h08) return 1'b0;
    if (a == 8'h00 || a == 8'h04) return wr;
    return 1'b1;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a, input logic sa, input logic sb);
    if (a == 8'h00) return {31'b0, sa};
    if (a == 8'h04) return {31'b0, sb};
    if (a == 8'h08) return model_word;
    return 32'h0;
  endfunction

  // Called on a falling edge; returns on a falling edge.
  task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output logic err,
                      output logic rdy_setup, output logic rdy_acc);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
    #5 rdy_setup = pready;
    @(negedge clk);
    penable = 1'b1;
    #5 rd = prdata; err = pslverr; rdy_acc = pready;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [31:0] rd, output logic err);
    logic rs, ra;
    xfer(1'b0, a, 32'h0, rd, err, rs, ra);
    chk("R2 setup ready", {31'b0, rs}, 32'd0);
    chk("R2 access ready", {31'b0, ra}, 32'd1);
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] wd, output logic err);
    logic [31:0] rd;
    logic rs, ra;
    xfer(1'b1, a, wd, rd, err, rs, ra);
    chk("R2 access ready", {31'b0, ra}, 32'd1);
    chk("R8 write prdata", rd, 32'h0);
    if (!exp_err(1'b1, a)) model_word = wd;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        err;
    void'($urandom(32'd7331));
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = 8'h0; pwdata = 32'h0; sw_a_in = 1'b0; sw_b_in = 1'b0;
    model_word = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    #5;
    chk("R1 prdata", prdata, 32'h0);
    chk("R1 pready", {31'b0, pready}, 32'h0);
    chk("R1 pslverr", {31'b0, pslverr}, 32'h0);
    @(negedge clk);
    do_rd(8'h08, rd, err);
    chk("R1 word reset", rd, 32'h0);

    // R10 / R2 / R7: psel low with other strobes active
    psel = 1'b0; penable = 1'b1; pwrite = 1'b1; paddr = 8'h08; pwdata = 32'hFFFF_FFFF;
    #5;
    chk("R10 prdata unselected", prdata, 32'h0);
    chk("R2 ready unselected", {31'b0, pready}, 32'h0);
    @(negedge clk);
    pwrite = 1'b0;
    #5 chk("R10 prdata unselected read", prdata, 32'h0);
    @(negedge clk);
    penable = 1'b0;
    do_rd(8'h08, rd, err);
    chk("R7 no write while unselected", rd, 32'h0);

    // R6 write then read
    do_wr(8'h08, 32'hA5A5_5A5A, err);
    chk("R11 word write okay", {31'b0, err}, 32'h0);
    do_rd(8'h08, rd, err);
    chk("R6 readback", rd, 32'hA5A5_5A5A);
    chk("R11 word read okay", {31'b0, err}, 32'h0);

    // R7 setup-only write
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 8'h08; pwdata = 32'h1234_5678;
    @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    @(negedge clk);
    do_rd(8'h08, rd, err);
    chk("R7 setup-only write ignored", rd, 32'hA5A5_5A5A);

    // R5 synchroniser window: change and start read on the same falling edge
    sw_a_in = 1'b1;
    do_rd(8'h00, rd, err);
    chk("R5 old level inside window", rd, 32'h0);
    do_rd(8'h00, rd, err);
    chk("R3 switch A high", rd, 32'h1);
    chk("R11 switch read okay", {31'b0, err}, 32'h0);
    do_rd(8'h04, rd, err);
    chk("R4 switch B low", rd, 32'h0);
    sw_b_in = 1'b1;
    do_rd(8'h04, rd, err);
    chk("R5 old level B inside window", rd, 32'h0);
    do_rd(8'h04, rd, err);
    chk("R4 switch B high", rd, 32'h1);
    sw_a_in = 1'b0;
    repeat (3) @(negedge clk);
    do_rd(8'h00, rd, err);
    chk("R3 switch A low", rd, 32'h0);

    // R9 writes to read-only switch words
    do_wr(8'h00, 32'hDEAD_BEEF, err);
    chk("R9 write switch A error", {31'b0, err}, 32'h1);
    do_wr(8'h04, 32'hCAFE_F00D, err);
    chk("R9 write switch B error", {31'b0, err}, 32'h1);
    do_rd(8'h08, rd, err);
    chk("R9 word unchanged", rd, 32'hA5A5_5A5A);

    // R8 unmapped offsets
    do_rd(8'h09, rd, err);
    chk("R8 read 0x09 error", {31'b0, err}, 32'h1);
    chk("R8 read 0x09 data", rd, 32'h0);
    do_rd(8'hFF, rd, err);
    chk("R8 read 0xFF error", {31'b0, err}, 32'h1);
    chk("R8 read 0xFF data", rd, 32'h0);
    do_wr(8'h0C, 32'h0BAD_0BAD, err);
    chk("R8 write 0x0C error", {31'b0, err}, 32'h1);
    do_rd(8'h08, rd, err);
    chk("R8 word unchanged", rd, 32'hA5A5_5A5A);

    // Random traffic
    for (int i = 0; i < 300; i++) begin
      logic [7:0]  a;
      logic        wr;
      logic [31:0] wd;
      int          pick;
      if (($urandom % 4) == 0) begin
        sw_a_in = $urandom % 2;
        sw_b_in = $urandom % 2;
        repeat (3) @(negedge clk);
      end
      pick = $urandom % 5;
      case (pick)
        0: a = 8'h00;
        1: a = 8'h04;
        2, 3: a = 8'h08;
        default: a = 8'($urandom);
      endcase
      wr = $urandom % 2;
      wd = $urandom;
      if (wr) begin
        do_wr(a, wd, err);
        chk("R8 R9 R11 random write response", {31'b0, err}, {31'b0, exp_err(1'b1, a)});
      end else begin
        do_rd(a, rd, err);
        chk("R3 R4 R6 R8 random read data", rd, exp_rd(a, sw_a_in, sw_b_in));
        chk("R8 R11 random read response", {31'b0, err}, {31'b0, exp_err(1'b0, a)});
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule